// File: doc/BRIEF.md
# Shared Counter with Per-Core Compare Timers

This block holds one free-running counter that every core in a cluster shares, plus one 64-bit compare register for each core. Software reaches all of it through a simple word-addressed 32-bit register bus. Because the counter is wider than the bus, software reads it in two halves. To get a coherent value it samples the upper half, then the lower half, then the upper half again. If the two upper-half samples differ, it retries. The block deliberately keeps no snapshot of the upper half, so a carry that lands between the reads is visible as a torn value.

The counter width is a build-time choice of 32 + 4·N bits, and N is reported in the configuration word. A stop bit in that word freezes the count and releases it again. Each core's timer interrupt stays high while the counter is at or beyond that core's compare value. Software clears it by writing a compare value that lies ahead of the count.

Top module: `shared_timer`

## Requirements
- R1: After reset the counter reads zero, the stop bit is set, every compare half reads 0xFFFFFFFF and every interrupt output is low.
- R2: Word address 0 is the configuration word. Bit 0 is the stop bit, and it is read/write. Bits 7:4 read back the width field N (default 4, so the counter is 48 bits) and ignore writes. All other bits read zero.
- R3: When the stop bit is clear, the counter advances by exactly one every clock cycle. When the stop bit is set, the counter holds its value. A write that changes the stop bit takes effect from the following cycle.
- R4: Word address 1 returns counter bits 31:0 and address 2 returns bits 63:32. Bits at or above the configured width read as zero. Read data follows the live counter combinationally and nothing is latched between the two reads, so an upper/lower/upper sequence taken across a carry returns two different upper values.
- R5: After the counter reaches its all-ones value at the configured width, it wraps to zero.
- R6: A write to address 1 or 2 loads that half of the counter, and the counter does not increment in the cycle of the load. Written bits at or above the configured width are discarded.
- R7: Core k's compare value is at address 4+2k for bits 31:0 and at 5+2k for bits 63:32. Each half reads back what was written to it and changes only when it is written.
- R8: Interrupt bit k is high in exactly those cycles where the counter is greater than or equal to core k's 64-bit compare value, with the counter zero-extended. Writing a compare value above the count drops the bit right after the write.
- R9: Address 3 and addresses above the last compare register read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (4) | Word address |
| bus_wr | input | 1 | Write strobe, takes effect at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tmr_irq | output | NUM_CORES (4) | Per-core timer interrupt |

## Verification
A corrupted counter shows up on the next read of address 1 or 2. If it is stuck, two reads one cycle apart return the same lower half. If the increment is wrong, the difference is not one. A compare register that holds the wrong value, or an interrupt flop out of step, shows on tmr_irq in the very cycle in which the count and the compare are related differently than the bench model expects. A snapshot of the upper half, where none should exist, appears as the absence of a torn value in the carry-crossing read sequence.

// File: rtl/shared_timer_pkg.sv
package shared_timer_pkg;
    localparam int BUS_W      = 32;
    localparam int ADR_CFG    = 0;
    localparam int ADR_CNT_LO = 1;
    localparam int ADR_CNT_HI = 2;
    localparam int ADR_CMP0   = 4;
    localparam int CFG_STOP   = 0;
    localparam int CFG_N_LSB  = 4;

    function automatic int cnt_width(input int ext_n);
        return 32 + 4 * ext_n;
    endfunction
endpackage

// File: rtl/shared_timer_count.sv
module shared_timer_count #(
    parameter int EXT_N = 4,
    parameter int CNT_W = shared_timer_pkg::cnt_width(EXT_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             lo_wr,
    input  logic             hi_wr,
    input  logic [31:0]      wdata,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_nxt_o,
    output logic             stop_o
);
    typedef struct packed {
        logic             stop;
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [63:0] wide;

    always_comb begin
        st_d = st_q;
        wide = 64'(st_q.cnt);
        // a load pre-empts the increment for that cycle
        if (!st_q.stop && !lo_wr && !hi_wr) begin
            wide = wide + 64'd1;
        end
        if (lo_wr) begin
            wide[31:0] = wdata;
        end
        if (hi_wr) begin
            wide[63:32] = wdata;
        end
        st_d.cnt = wide[CNT_W-1:0];
        if (cfg_wr) begin
            st_d.stop = wdata[shared_timer_pkg::CFG_STOP];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{stop: 1'b1, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o     = st_q.cnt;
    assign cnt_nxt_o = st_d.cnt;
    assign stop_o    = st_q.stop;

    // R3
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stop && !lo_wr && !hi_wr) |=> $stable(cnt_o));

    // R3
    run_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.stop && !lo_wr && !hi_wr) |=> (cnt_o == CNT_W'($past(cnt_o) + 1'b1)));
endmodule

// File: rtl/shared_timer_cmp.sv
module shared_timer_cmp #(
    parameter int NUM_CORES = 4,
    parameter int CNT_W     = 48
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_CORES-1:0]        lo_wr,
    input  logic [NUM_CORES-1:0]        hi_wr,
    input  logic [31:0]                 wdata,
    input  logic [CNT_W-1:0]            cnt_i,
    input  logic [CNT_W-1:0]            cnt_nxt_i,
    output logic [NUM_CORES-1:0][63:0]  cmp_o,
    output logic [NUM_CORES-1:0]        irq_o
);
    typedef struct packed {
        logic [NUM_CORES-1:0][63:0] cmp;
        logic [NUM_CORES-1:0]       irq;
    } cmp_st_t;

    cmp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NUM_CORES; k++) begin
            if (lo_wr[k]) begin
                st_d.cmp[k][31:0] = wdata;
            end
            if (hi_wr[k]) begin
                st_d.cmp[k][63:32] = wdata;
            end
            // flag follows the state the registers are about to hold
            st_d.irq[k] = (64'(cnt_nxt_i) >= st_d.cmp[k]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cmp <= '1;
            st_q.irq <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmp_o = st_q.cmp;
    assign irq_o = st_q.irq;

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
        // R8
        irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[g] == (64'(cnt_i) >= cmp_o[g]));

        // R7
        cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!lo_wr[g] && !hi_wr[g]) |=> $stable(cmp_o[g]));
    end
endmodule

// File: rtl/shared_timer_regs.sv
module shared_timer_regs #(
    parameter int NUM_CORES = 4,
    parameter int EXT_N     = 4,
    parameter int CNT_W     = shared_timer_pkg::cnt_width(EXT_N),
    parameter int ADDR_W    = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_wr,
    input  logic [CNT_W-1:0]           cnt_i,
    input  logic                       stop_i,
    input  logic [NUM_CORES-1:0][63:0] cmp_i,
    output logic                       cfg_wr,
    output logic                       lo_wr,
    output logic                       hi_wr,
    output logic [NUM_CORES-1:0]       cmp_lo_wr,
    output logic [NUM_CORES-1:0]       cmp_hi_wr,
    output logic [31:0]                rdata
);
    import shared_timer_pkg::*;

    localparam int HI_BITS = CNT_W - 32;
    localparam logic [31:0] HI_MASK = (HI_BITS >= 32) ? '1 : 32'((33'd1 << HI_BITS) - 33'd1);
    localparam int LAST_ADR = ADR_CMP0 + 2 * NUM_CORES - 1;

    logic [63:0] cnt_wide;
    assign cnt_wide = 64'(cnt_i);

    always_comb begin
        cfg_wr = bus_wr && (bus_addr == ADDR_W'(ADR_CFG));
        lo_wr  = bus_wr && (bus_addr == ADDR_W'(ADR_CNT_LO));
        hi_wr  = bus_wr && (bus_addr == ADDR_W'(ADR_CNT_HI));
        for (int k = 0; k < NUM_CORES; k++) begin
            cmp_lo_wr[k] = bus_wr && (bus_addr == ADDR_W'(ADR_CMP0 + 2 * k));
            cmp_hi_wr[k] = bus_wr && (bus_addr == ADDR_W'(ADR_CMP0 + 2 * k + 1));
        end

        rdata = '0;
        if (bus_addr == ADDR_W'(ADR_CFG)) begin
            rdata[CFG_STOP] = stop_i;
            rdata[CFG_N_LSB +: 4] = 4'(EXT_N);
        end
        if (bus_addr == ADDR_W'(ADR_CNT_LO)) begin
            rdata = cnt_wide[31:0];
        end
        if (bus_addr == ADDR_W'(ADR_CNT_HI)) begin
            rdata = cnt_wide[63:32];
        end
        for (int k = 0; k < NUM_CORES; k++) begin
            if (bus_addr == ADDR_W'(ADR_CMP0 + 2 * k)) begin
                rdata = cmp_i[k][31:0];
            end
            if (bus_addr == ADDR_W'(ADR_CMP0 + 2 * k + 1)) begin
                rdata = cmp_i[k][63:32];
            end
        end
    end

    // R2
    cfg_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(ADR_CFG)) |-> (rdata[CFG_N_LSB +: 4] == 4'(EXT_N)));

    // R4
    hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(ADR_CNT_HI)) |-> ((rdata & ~HI_MASK) == 32'd0));

    // R9
    hole_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_addr == ADDR_W'(3)) || (32'(bus_addr) > LAST_ADR)) |-> (rdata == 32'd0));
endmodule

// File: rtl/shared_timer.sv
module shared_timer #(
    parameter int NUM_CORES = 4,
    parameter int EXT_N     = 4,
    parameter int ADDR_W    = $clog2(shared_timer_pkg::ADR_CMP0 + 2 * NUM_CORES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_CORES-1:0] tmr_irq
);
    localparam int CNT_W = shared_timer_pkg::cnt_width(EXT_N);

    logic                       cfg_wr, lo_wr, hi_wr, stop;
    logic [NUM_CORES-1:0]       cmp_lo_wr, cmp_hi_wr;
    logic [CNT_W-1:0]           cnt, cnt_nxt;
    logic [NUM_CORES-1:0][63:0] cmp;

    shared_timer_regs #(
        .NUM_CORES(NUM_CORES), .EXT_N(EXT_N), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .cnt_i(cnt), .stop_i(stop), .cmp_i(cmp),
        .cfg_wr(cfg_wr), .lo_wr(lo_wr), .hi_wr(hi_wr),
        .cmp_lo_wr(cmp_lo_wr), .cmp_hi_wr(cmp_hi_wr), .rdata(bus_rdata)
    );

    shared_timer_count #(.EXT_N(EXT_N), .CNT_W(CNT_W)) i_count (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .lo_wr(lo_wr), .hi_wr(hi_wr),
        .wdata(bus_wdata), .cnt_o(cnt), .cnt_nxt_o(cnt_nxt), .stop_o(stop)
    );

    shared_timer_cmp #(.NUM_CORES(NUM_CORES), .CNT_W(CNT_W)) i_cmp (
        .clk(clk), .rst_n(rst_n), .lo_wr(cmp_lo_wr), .hi_wr(cmp_hi_wr),
        .wdata(bus_wdata), .cnt_i(cnt), .cnt_nxt_i(cnt_nxt),
        .cmp_o(cmp), .irq_o(tmr_irq)
    );
endmodule

// File: tb/test_shared_timer.sv
module test_shared_timer;
    localparam int NC    = 4;
    localparam int CNT_W = 48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NC-1:0] tmr_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [63:0] m_cnt;
    logic [63:0] m_cmp [NC];

    always #4 clk = ~clk;

    shared_timer i_shared_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_irq(tmr_irq)
    );

    function automatic logic [NC-1:0] exp_irq();
        logic [NC-1:0] r;
        for (int k = 0; k < NC; k++) r[k] = (m_cnt >= m_cmp[k]);
        return r;
    endfunction

    function automatic logic [63:0] wmask(input logic [63:0] v);
        return v & ((64'd1 << CNT_W) - 64'd1);
    endfunction

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = 4'(a); bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = 4'(a);
        #1 d = bus_rdata;
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            report();
        end
    end

    initial begin
        logic [31:0] v, h1, lo, h2;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R2 configuration word
        rd(0, v);  chk("R1/R2 cfg after reset", 64'(v), 64'h41);
        rd(1, v);  chk("R1 cnt lo", 64'(v), 0);
        rd(2, v);  chk("R1 cnt hi", 64'(v), 0);
        for (int a = 4; a < 12; a++) begin
            rd(a, v); chk("R1 cmp reset", 64'(v), 64'hFFFF_FFFF);
        end
        chk("R1 irq reset", 64'(tmr_irq), 0);
        m_cnt = 0;
        for (int k = 0; k < NC; k++) m_cmp[k] = '1;

        // R2 width field ignores writes
        wr(0, 32'hFFFF_FFF1);
        rd(0, v); chk("R2 N field write ignored", 64'(v), 64'h41);

        // R3 stopped counter holds
        rd(1, h1); rd(1, h2); rd(1, v);
        chk("R3 stopped hold", 64'(v), 64'(h1));

        // R4/R6 bits above width discarded
        wr(2, 32'hFFFF_FFFF);
        rd(2, v); chk("R4 hi bits above width", 64'(v), 64'h0000_FFFF);
        m_cnt = 64'hFFFF_0000_0000;

        // R6/R7/R8 random register traffic with counter stopped
        for (int i = 0; i < 60; i++) begin
            int sel = int'($urandom % 4);
            int k = int'($urandom % NC);
            logic [31:0] d = $urandom;
            int a;
            if ($urandom % 2 == 0 && sel == 3) d = d & 32'h1;
            case (sel)
                0: begin a = 1; m_cnt = wmask({m_cnt[63:32], d}); end
                1: begin a = 2; m_cnt = wmask({d, m_cnt[31:0]}); end
                2: begin a = 4 + 2 * k; m_cmp[k][31:0] = d; end
                default: begin a = 5 + 2 * k; m_cmp[k][63:32] = d; end
            endcase
            wr(a, d);
            rd(a, v);
            case (sel)
                0: chk("R6 cnt lo load", 64'(v), 64'(m_cnt[31:0]));
                1: chk("R6 cnt hi load", 64'(v), 64'(m_cnt[63:32]));
                2: chk("R7 cmp lo readback", 64'(v), 64'(m_cmp[k][31:0]));
                default: chk("R7 cmp hi readback", 64'(v), 64'(m_cmp[k][63:32]));
            endcase
            chk("R8 irq vs model", 64'(tmr_irq), 64'(exp_irq()));
        end

        // R9 holes read zero and writes change nothing
        wr(3, 32'hDEAD_BEEF);  rd(3, v);  chk("R9 hole 3 reads zero", 64'(v), 0);
        wr(15, 32'h1234_5678); rd(15, v); chk("R9 hole 15 reads zero", 64'(v), 0);
        wr(12, 32'h0); rd(12, v); chk("R9 hole 12 reads zero", 64'(v), 0);
        rd(1, v); chk("R9 cnt lo untouched", 64'(v), 64'(m_cnt[31:0]));
        rd(0, v); chk("R9 cfg untouched", 64'(v), 64'h41);
        for (int k = 0; k < NC; k++) begin
            rd(4 + 2 * k, v); chk("R9 cmp untouched", 64'(v), 64'(m_cmp[k][31:0]));
        end
        chk("R9 irq untouched", 64'(tmr_irq), 64'(exp_irq()));

        // park compares high so later phases are predictable
        for (int k = 0; k < NC; k++) begin
            wr(5 + 2 * k, 32'hFFFF_FFFF); m_cmp[k][63:32] = '1;
        end

        // R4 torn read across a carry
        wr(2, 32'h0000_0007); wr(1, 32'hFFFF_FFFF);
        wr(0, 32'h0);
        rd(2, h1); rd(1, lo); rd(2, h2);
        chk("R4 first hi", 64'(h1), 64'h7);
        chk("R4 lo after carry", 64'(lo), 64'h0);
        chk("R4 second hi torn", 64'(h2), 64'h8);

        // R6 load while running, then R3 stepping
        wr(1, 32'd100);
        for (int i = 0; i < 6; i++) begin
            rd(1, v); chk("R3/R6 run step", 64'(v), 64'(100 + i));
        end
        wr(0, 32'h1);
        rd(1, h1); rd(1, h2);
        chk("R3 stop holds", 64'(h2), 64'(h1));

        // R5 wrap at 48 bits
        wr(2, 32'hFFFF_FFFF); wr(1, 32'hFFFF_FFFD);
        wr(0, 32'h0);
        rd(1, v); chk("R5 pre-wrap 0", 64'(v), 64'hFFFF_FFFD);
        rd(1, v); chk("R5 pre-wrap 1", 64'(v), 64'hFFFF_FFFE);
        rd(1, v); chk("R5 pre-wrap 2", 64'(v), 64'hFFFF_FFFF);
        rd(2, v); chk("R5 wrapped hi", 64'(v), 0);
        rd(1, v); chk("R5 wrapped lo", 64'(v), 1);
        wr(0, 32'h1);

        // R8 rise on reaching compare, clear by new compare
        wr(2, 0); wr(1, 32'd100);
        wr(4, 32'd103); wr(5, 32'd0);
        rd(1, v); chk("R8 irq low before start", 64'(tmr_irq[0]), 0);
        wr(0, 32'h0);
        for (int i = 0; i < 8; i++) begin
            rd(1, v);
            chk("R8 count while armed", 64'(v), 64'(100 + i));
            chk("R8 irq at compare", 64'(tmr_irq[0]), 64'((100 + i) >= 103));
            chk("R8 other cores quiet", 64'(tmr_irq[NC-1:1]), 0);
        end
        wr(5, 32'd1);
        rd(5, v);
        chk("R8 irq cleared by compare write", 64'(tmr_irq[0]), 0);

        done = 1'b1;
        report();
    end
endmodule